// File: doc/BRIEF.md
# Pad Input Conditioner and Event Detector

This block conditions the raw input levels of a small group of pads and detects events on them. Each pad passes through two synchronizer stages in series. Every stage has its own mode: it can be skipped, register on the falling clock edge, or register on the rising clock edge. The result is the conditioned level of the pin. It goes to a readable level vector and to a per-pin trigger detector.

Each pin's detector watches for one trigger condition, chosen from its configuration word: a rising edge, a falling edge, either edge, a low level or a high level. The detector raises the pin's bit in a source vector for as long as that condition is valid. The status logic next to the block uses that vector, one cycle at a time, as its set request. Each pin also has a sticky wake flag. The flag captures edge events while wake-up is enabled for that pin, and a clear strobe in the configuration word drops it. One output reports whether any wake flag is set.

The configuration words come from a register file elsewhere, packed one word per pin. This block only decodes them.

Top module: `gpio_evt_top`

## Requirements
- R1: After reset, with all pads low, the level, source, wake flag and any-wake outputs are all zero.
- R2: A stage whose 2-bit mode is 0 passes its input straight through. With both stages in mode 0, the level output follows the pad within the same clock cycle.
- R3: A stage in mode 1 registers its input on the falling clock edge. A stage in mode 2 or 3 registers on the rising clock edge. Modes 2 and 3 behave the same. The first stage's mode is in configuration bits [4:3] and the second stage's mode is in bits [1:0].
- R4: The conditioned value reaches the level output after the delays of both stages have added up. Both stages on the rising edge take two rising edges. A falling-edge stage followed by a rising-edge stage takes one rising edge.
- R5: The trigger type is in configuration bits [9:7]. For code 1 (rising), 2 (falling) and 3 (either edge), the pin's source bit is high from the change of the conditioned level until the next rising clock edge.
- R6: For code 4 (low level) and code 5 (high level), the source bit is high on every cycle the conditioned level matches, so it asks to set the status bit again on each cycle.
- R7: Trigger codes 0, 6 and 7 never raise the source bit.
- R8: When configuration bit 10 is set, a qualifying edge (code 1, 2 or 3) sets the pin's wake flag at the next rising clock edge. The flag then stays set. Level triggers and pins with bit 10 clear never set it.
- R9: Configuration bit 5 is a clear strobe. Any cycle in which it is 1 clears the wake flag at the next rising clock edge, and the clear wins over a coincident edge.
- R10: The any-wake output is the OR of all pins' wake flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock; both edges are used by the synchronizer stages |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | NPIN | Raw pad levels |
| pin_cfg | input | NPIN*CFG_W | Packed configuration words, pin 0 in the lowest slice |
| in_level | output | NPIN | Conditioned level of each pin |
| evt_src | output | NPIN | Per-pin trigger-valid vector, also the status set request |
| wake_flag | output | NPIN | Sticky edge wake flag of each pin |
| wake_any | output | 1 | OR of all wake flags |

## Verification
The bench runs every combination of stage modes that matters and checks the level one cycle before and at the cycle the latency predicts. A stage that sampled on the wrong edge, or that treated mode 3 differently from mode 2, would make the value arrive a cycle early or late. It sets all eight trigger codes at once across the pins and drives both edge directions. A detector that held an edge event for longer than one edge, or that decoded codes 6 or 7, would leave extra bits in the source vector. For the wake flag, the bench checks that the flag persists, that a pin without wake enabled or with a level trigger stays clear, and that a clear strobe arriving together with an edge leaves the flag cleared.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

   typedef enum logic [1:0] {
      SYN_BYP      = 2'd0,
      SYN_FALL     = 2'd1,
      SYN_RISE     = 2'd2,
      SYN_RISE_ALT = 2'd3
   } syn_mode_e;

   typedef enum logic [2:0] {
      TRG_OFF  = 3'd0,
      TRG_RISE = 3'd1,
      TRG_FALL = 3'd2,
      TRG_ANY  = 3'd3,
      TRG_LOW  = 3'd4,
      TRG_HIGH = 3'd5,
      TRG_RSV6 = 3'd6,
      TRG_RSV7 = 3'd7
   } trg_e;

   // field positions inside one pin's configuration word
   localparam int CFG_S2_LSB  = 0;
   localparam int CFG_S1_LSB  = 3;
   localparam int CFG_CLR_BIT = 5;
   localparam int CFG_TRG_LSB = 7;
   localparam int CFG_WEN_BIT = 10;
   localparam int CFG_MIN_W   = CFG_WEN_BIT + 1;

   typedef struct packed {
      logic      wen;
      trg_e      trg;
      logic      clr;
      syn_mode_e s1;
      syn_mode_e s2;
   } pin_ctl_t;

endpackage

// File: rtl/gpio_sync_stage.sv
module gpio_sync_stage
   import gpio_evt_pkg::*;
#(
   parameter logic RST_VAL = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  syn_mode_e mode,
   input  logic      d,
   output logic      q
);

   logic rise_q;
   logic fall_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rise_q <= RST_VAL;
      else        rise_q <= d;
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) fall_q <= RST_VAL;
      else        fall_q <= d;
   end

   always_comb begin
      unique case (mode)
         SYN_BYP:  q = d;
         SYN_FALL: q = fall_q;
         default:  q = rise_q;
      endcase
   end

   // R3: in a rising-edge mode the stage output lags its input by one rising edge
   assert_rise_mode_lag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[1] && $past(rst_n)) |-> (q == $past(d)));

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
   import gpio_evt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  trg_e trg,
   input  logic wen,
   input  logic clr,
   output logic src,
   output logic wake
);

   logic prev_q;
   logic rise_ev;
   logic fall_ev;
   logic edge_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign rise_ev = lvl & ~prev_q;
   assign fall_ev = ~lvl & prev_q;

   always_comb begin
      edge_hit = 1'b0;
      src      = 1'b0;
      unique case (trg)
         TRG_RISE: begin edge_hit = rise_ev;           src = rise_ev;           end
         TRG_FALL: begin edge_hit = fall_ev;           src = fall_ev;           end
         TRG_ANY:  begin edge_hit = rise_ev | fall_ev; src = rise_ev | fall_ev; end
         TRG_LOW:  src = ~lvl;
         TRG_HIGH: src = lvl;
         default:  src = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               wake <= 1'b0;
      else if (clr)             wake <= 1'b0;
      else if (wen && edge_hit) wake <= 1'b1;
   end

   assert_no_src_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (trg == TRG_OFF || trg == TRG_RSV6 || trg == TRG_RSV7) |-> !src);

   assert_rise_src_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (trg == TRG_RISE && src) |-> lvl);

   assert_wake_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wake && !clr) |=> wake);

   assert_wake_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake) |-> $past(wen));

   assert_wake_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !wake);

endmodule

// File: rtl/gpio_evt_top.sv
module gpio_evt_top
   import gpio_evt_pkg::*;
#(
   parameter int NPIN  = 8,
   parameter int CFG_W = 11
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NPIN-1:0]         pad_in,
   input  logic [NPIN*CFG_W-1:0]   pin_cfg,
   output logic [NPIN-1:0]         in_level,
   output logic [NPIN-1:0]         evt_src,
   output logic [NPIN-1:0]         wake_flag,
   output logic                    wake_any
);

   localparam int CFG_TOT = NPIN * CFG_W;

   if (NPIN < 1) begin : g_bad_npin
      $error("gpio_evt_top: NPIN must be at least 1");
   end
   if (CFG_W < CFG_MIN_W) begin : g_bad_cfgw
      $error("gpio_evt_top: CFG_W too narrow for the configuration fields");
   end
   if (CFG_TOT < CFG_W) begin : g_bad_tot
      $error("gpio_evt_top: configuration bus width inconsistent");
   end

   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      logic [CFG_W-1:0] word;
      pin_ctl_t         ctl;
      logic             mid;

      assign word    = pin_cfg[p*CFG_W +: CFG_W];
      assign ctl.s2  = syn_mode_e'(word[CFG_S2_LSB +: 2]);
      assign ctl.s1  = syn_mode_e'(word[CFG_S1_LSB +: 2]);
      assign ctl.clr = word[CFG_CLR_BIT];
      assign ctl.trg = trg_e'(word[CFG_TRG_LSB +: 3]);
      assign ctl.wen = word[CFG_WEN_BIT];

      gpio_sync_stage #(.RST_VAL(1'b0)) u_first (
         .clk   (clk),
         .rst_n (rst_n),
         .mode  (ctl.s1),
         .d     (pad_in[p]),
         .q     (mid)
      );

      gpio_sync_stage #(.RST_VAL(1'b0)) u_second (
         .clk   (clk),
         .rst_n (rst_n),
         .mode  (ctl.s2),
         .d     (mid),
         .q     (in_level[p])
      );

      gpio_evt_detect u_det (
         .clk   (clk),
         .rst_n (rst_n),
         .lvl   (in_level[p]),
         .trg   (ctl.trg),
         .wen   (ctl.wen),
         .clr   (ctl.clr),
         .src   (evt_src[p]),
         .wake  (wake_flag[p])
      );
   end

   assign wake_any = |wake_flag;

   // R2: with both stages skipped the level is the pad itself
   assert_bypass_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_cfg[CFG_S1_LSB +: 2] == 2'd0 && pin_cfg[CFG_S2_LSB +: 2] == 2'd0)
      |-> (in_level[0] == pad_in[0]));

   // R10: the summary is set exactly when some pin's flag is set
   assert_any_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_any) |-> ($countones(wake_flag) != 0));

endmodule

// File: tb/sim_gpio_evt_top.sv
module sim_gpio_evt_top;

   localparam int CLK_PERIOD = 10;
   localparam int NPIN = 8;
   localparam int CFG_W = 11;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic [NPIN-1:0]       pad_in = '0;
   logic [NPIN*CFG_W-1:0] pin_cfg = '0;
   logic [NPIN-1:0]       in_level;
   logic [NPIN-1:0]       evt_src;
   logic [NPIN-1:0]       wake_flag;
   logic                  wake_any;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   typedef struct {
      int         due;
      int         kind;   // 0 level, 1 source, 2 wake flags, 3 any-wake
      logic [7:0] exp;
      string      tag;
   } sb_item_t;

   sb_item_t sb[$];
   sb_item_t mon_it;

   gpio_evt_top #(.NPIN(NPIN), .CFG_W(CFG_W)) u0 (
      .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pin_cfg(pin_cfg),
      .in_level(in_level), .evt_src(evt_src), .wake_flag(wake_flag),
      .wake_any(wake_any)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [CFG_W-1:0] mk(input int s1, input int s2,
                                           input int trg, input bit wen, input bit clr);
      logic [CFG_W-1:0] v = '0;
      v[1:0] = s2[1:0];
      v[4:3] = s1[1:0];
      v[5]   = clr;
      v[9:7] = trg[2:0];
      v[10]  = wen;
      return v;
   endfunction

   task automatic tick();
      @(posedge clk);
      #3;
   endtask

   task automatic expect_at(input int kind, input logic [7:0] exp,
                            input int dly, input string tag);
      sb_item_t it;
      it.due = cyc + dly; it.kind = kind; it.exp = exp; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic drain();
      while (sb.size() > 0) @(posedge clk);
      #3;
   endtask

   task automatic all_cfg(input logic [CFG_W-1:0] w);
      for (int p = 0; p < NPIN; p++) pin_cfg[p*CFG_W +: CFG_W] = w;
   endtask

   // monitor: compares scoreboard items well after both clock edges
   always @(posedge clk) begin
      #8;
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         logic [7:0] act;
         mon_it = sb.pop_front();
         case (mon_it.kind)
            0: act = in_level;
            1: act = evt_src;
            2: act = wake_flag;
            default: act = {7'd0, wake_any};
         endcase
         checks++;
         if (mon_it.due != cyc || act !== mon_it.exp) begin
            errors++;
            $display("FAIL %s kind %0d cycle %0d: actual %h expected %h",
                     mon_it.tag, mon_it.kind, cyc, act, mon_it.exp);
         end
      end
   end

   // latency check for one stage-mode pair: old value one cycle before, new value at L
   task automatic lat_case(input int s1, input int s2, input int lat, input string tag);
      all_cfg(mk(s1, s2, 0, 1'b0, 1'b0));
      pad_in = 8'h00;
      repeat (4) tick();
      pad_in = 8'hA5;
      if (lat > 0) expect_at(0, 8'h00, lat - 1, tag);
      expect_at(0, 8'hA5, lat, tag);
      drain();
      pad_in = 8'h00;
      repeat (4) tick();
   endtask

   initial begin
      tick();
      tick();
      rst_n = 1'b1;
      // R1 reset state
      expect_at(0, 8'h00, 0, "R1");
      expect_at(1, 8'h00, 0, "R1");
      expect_at(2, 8'h00, 0, "R1");
      expect_at(3, 8'h00, 0, "R1");
      drain();

      // R2 / R3 / R4 stage modes and latencies
      lat_case(0, 0, 0, "R2");
      lat_case(2, 2, 2, "R4");
      lat_case(3, 3, 2, "R3");
      lat_case(1, 2, 1, "R4");
      lat_case(2, 1, 1, "R3");
      lat_case(1, 1, 1, "R3");
      lat_case(0, 1, 0, "R3");
      lat_case(0, 3, 1, "R3");
      lat_case(3, 0, 1, "R3");

      // R5 R6 R7: pin p uses trigger code p, both stages skipped
      for (int p = 0; p < NPIN; p++) pin_cfg[p*CFG_W +: CFG_W] = mk(0, 0, p, 1'b0, 1'b0);
      pad_in = 8'h00;
      repeat (3) tick();
      expect_at(1, 8'h10, 0, "R6");
      drain();
      pad_in = 8'hFF;
      expect_at(1, 8'h2A, 0, "R5");
      expect_at(1, 8'h20, 1, "R6");
      expect_at(1, 8'h20, 3, "R7");
      drain();
      pad_in = 8'h00;
      expect_at(1, 8'h1C, 0, "R5");
      expect_at(1, 8'h10, 1, "R7");
      drain();

      // R8 R10: pin1 rising with wake, pin3 either edge without wake, pin5 high level with wake
      all_cfg(mk(0, 0, 0, 1'b0, 1'b0));
      pin_cfg[1*CFG_W +: CFG_W] = mk(0, 0, 1, 1'b1, 1'b0);
      pin_cfg[3*CFG_W +: CFG_W] = mk(0, 0, 3, 1'b0, 1'b0);
      pin_cfg[5*CFG_W +: CFG_W] = mk(0, 0, 5, 1'b1, 1'b0);
      pad_in = 8'h00;
      repeat (3) tick();
      expect_at(2, 8'h00, 0, "R8");
      drain();
      pad_in = 8'hFF;
      expect_at(1, 8'h2A, 0, "R5");
      expect_at(2, 8'h00, 0, "R8");
      expect_at(2, 8'h02, 1, "R8");
      expect_at(3, 8'h01, 1, "R10");
      expect_at(2, 8'h02, 4, "R8");
      drain();

      // R9: clear strobe drops the flag
      pin_cfg[1*CFG_W +: CFG_W] = mk(0, 0, 1, 1'b1, 1'b1);
      expect_at(2, 8'h02, 0, "R9");
      expect_at(2, 8'h00, 1, "R9");
      expect_at(3, 8'h00, 1, "R10");
      tick();
      pin_cfg[1*CFG_W +: CFG_W] = mk(0, 0, 1, 1'b1, 1'b0);
      drain();

      // R9: clear wins over a coincident edge
      pad_in = 8'h00;
      repeat (3) tick();
      pad_in = 8'hFF;
      pin_cfg[1*CFG_W +: CFG_W] = mk(0, 0, 1, 1'b1, 1'b1);
      expect_at(2, 8'h00, 1, "R9");
      tick();
      pin_cfg[1*CFG_W +: CFG_W] = mk(0, 0, 1, 1'b1, 1'b0);
      expect_at(2, 8'h00, 1, "R9");
      expect_at(3, 8'h00, 1, "R10");
      drain();

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hang expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule